// File: doc/BRIEF.md
# Dual-Chain Bidirectional Latched Output Driver

This block is the digital core of a 64-output serial-to-parallel display driver. Two 32-stage shift chains run from one clock, so each clock with shifting enabled takes in two serial bits, one per chain. Chain 0 feeds parallel outputs 1 to 32 and chain 1 feeds outputs 33 to 64. Each chain has two end pins, an A side and a B side. A direction input picks which end takes in data and which end drives it out, so the same part can be cascaded in either sense.

A bank of output latches sits after the chains. While the latch enable is high the latches pass the chain contents straight through. While it is low they hold their value. A blanking input forces every parallel output low and does not disturb the latches. A cascade output always shows the final stage of chain 1, which is output 64. The latch enable and blanking inputs never touch the chains.

The serial interface has no back-pressure. The chains accept one bit per chain on every rising clock edge that has `shift_en` high, and no ready signal is needed. Bidirectional pins appear as separate in, out and output-enable signals for each pin, and an external pad joins them.

Top module: `dual_chain_driver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both chains and all latches. After reset every parallel output, the cascade output and every pin output is 0.
- R2: With `dir`=1 and `shift_en`=1, each chain loads `a_in[c]` into its first stage (output 1 for chain 0, output 33 for chain 1) and moves every stage one position toward the last stage. A bit entered on edge k reaches output 32 (or 64) after edge k+31.
- R3: With `dir`=0 and `shift_en`=1, each chain loads `b_in[c]` into its last stage (output 32 or 64) and moves every stage one position toward the first stage.
- R4: Both chains shift on the same edge. With `shift_en`=0 neither chain changes.
- R5: With `dir`=1, `b_oe[c]`=1, `a_oe[c]`=0, `b_out[c]` shows the chain's last stage and `a_out[c]`=0. With `dir`=0, `a_oe[c]`=1, `b_oe[c]`=0, `a_out[c]` shows the first stage and `b_out[c]`=0.
- R6: While `le`=1 and `blank_n`=1, `drv_out` equals the current chain contents. Bit j of `drv_out` is output j+1, and bits 31:0 come from chain 0.
- R7: While `le`=0, `drv_out` keeps the contents held at the last edge with `le`=1, even while the chains shift.
- R8: While `blank_n`=0 all of `drv_out` is 0 and the latch contents are kept. When `blank_n` returns to 1 the latched data shows again.
- R9: `ser_out` always equals the last stage of chain 1 (output 64), for either direction.
- R10: `le` and `blank_n` have no effect on shifting. The chain contents seen on `ser_out` and the pin outputs do not depend on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and latch clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift both chains on this edge |
| dir | input | 1 | 1: A side in, B side out; 0: B side in, A side out |
| a_in | input | 2 | A-side pin input, one per chain |
| a_out | output | 2 | A-side pin output value |
| a_oe | output | 2 | A-side pin output enable |
| b_in | input | 2 | B-side pin input, one per chain |
| b_out | output | 2 | B-side pin output value |
| b_oe | output | 2 | B-side pin output enable |
| le | input | 1 | Latch enable: 1 transparent, 0 hold |
| blank_n | input | 1 | Active-low blanking of all outputs |
| ser_out | output | 1 | Cascade output, final stage of chain 1 |
| drv_out | output | 64 | Parallel outputs 1..64 (bit 0 = output 1) |

## Verification
A wrong stage in a chain shows on the parallel outputs on the next edge while the latches are transparent. If it sits further in, it shows on the pin and cascade outputs only after enough shifts carry it to an end, up to 31 edges later. A latch fault shows only while `le` is low and the chains have moved on. A blanking fault that damages the latches shows only when blanking is released. The bench therefore shifts full chain lengths in both directions and releases blanking with the latches closed.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam logic DIR_FWD = 1'b1;
  localparam logic DIR_REV = 1'b0;
endpackage

// File: rtl/dcd_chain.sv
module dcd_chain #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           dir,
  input  logic           a_in,
  input  logic           b_in,
  output logic           a_out,
  output logic           a_oe,
  output logic           b_out,
  output logic           b_oe,
  output logic [LEN-1:0] q,
  output logic [LEN-1:0] d
);
  import dcd_pkg::*;

  logic [LEN-1:0] sr_q;

  always_comb begin
    if (!shift_en)           d = sr_q;
    else if (dir == DIR_FWD) d = {sr_q[LEN-2:0], a_in};
    else                     d = {b_in, sr_q[LEN-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= d;
  end

  assign q     = sr_q;
  assign a_oe  = (dir == DIR_REV);
  assign b_oe  = (dir == DIR_FWD);
  assign a_out = (dir == DIR_REV) ? sr_q[0] : 1'b0;
  assign b_out = (dir == DIR_FWD) ? sr_q[LEN-1] : 1'b0;

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));
  assert_fwd_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir == DIR_FWD) |=> sr_q[0] == $past(a_in));
  assert_rev_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir == DIR_REV) |=> sr_q[LEN-1] == $past(b_in));
endmodule

// File: rtl/dcd_latch_bank.sv
module dcd_latch_bank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] sr_q,
  input  logic [W-1:0] sr_d,
  output logic [W-1:0] view
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)     hold_q <= '0;
    else if (le) hold_q <= sr_d;
  end

  assign view = le ? sr_q : hold_q;

  assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
    !le |=> $stable(hold_q));
endmodule

// File: rtl/dcd_blank.sv
module dcd_blank #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blank_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  assign dout = blank_n ? din : '0;

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (blank_n && $past(blank_n) && $stable(din)) |-> $stable(dout));
endmodule

// File: rtl/dual_chain_driver.sv
module dual_chain_driver #(
  parameter int CHAIN_LEN  = 32,
  parameter int NUM_CHAINS = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            shift_en,
  input  logic                            dir,
  input  logic [NUM_CHAINS-1:0]           a_in,
  output logic [NUM_CHAINS-1:0]           a_out,
  output logic [NUM_CHAINS-1:0]           a_oe,
  input  logic [NUM_CHAINS-1:0]           b_in,
  output logic [NUM_CHAINS-1:0]           b_out,
  output logic [NUM_CHAINS-1:0]           b_oe,
  input  logic                            le,
  input  logic                            blank_n,
  output logic                            ser_out,
  output logic [CHAIN_LEN*NUM_CHAINS-1:0] drv_out
);
  import dcd_pkg::*;

  localparam int OUT_W = CHAIN_LEN * NUM_CHAINS;
  localparam int LAST  = OUT_W - 1;

  logic [OUT_W-1:0] sr_q_all, sr_d_all, view;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    dcd_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk(clk), .rst(rst), .shift_en(shift_en), .dir(dir),
      .a_in(a_in[c]), .b_in(b_in[c]),
      .a_out(a_out[c]), .a_oe(a_oe[c]),
      .b_out(b_out[c]), .b_oe(b_oe[c]),
      .q(sr_q_all[c*CHAIN_LEN +: CHAIN_LEN]),
      .d(sr_d_all[c*CHAIN_LEN +: CHAIN_LEN])
    );
  end

  dcd_latch_bank #(.W(OUT_W)) u_latch (
    .clk(clk), .rst(rst), .le(le),
    .sr_q(sr_q_all), .sr_d(sr_d_all), .view(view)
  );

  dcd_blank #(.W(OUT_W)) u_blank (
    .clk(clk), .rst(rst), .blank_n(blank_n), .din(view), .dout(drv_out)
  );

  assign ser_out = sr_q_all[LAST];

  assert_cascade_R9: assert property (@(posedge clk) disable iff (rst)
    (shift_en && dir == DIR_FWD && !$past(rst)) |=> ser_out == $past(sr_q_all[LAST-1]));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ser_out == 1'b0 && a_out == '0 && b_out == '0));
endmodule

// File: tb/test_dual_chain_driver.sv
module test_dual_chain_driver;
  localparam int N = 32;

  typedef struct {
    logic [63:0] par;
    logic        ser;
    logic [7:0]  pins;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1, shift_en = 1'b0, dir = 1'b1, le = 1'b1, blank_n = 1'b1;
  logic [1:0] a_in = '0, b_in = '0;
  logic [1:0] a_out, a_oe, b_out, b_oe;
  logic ser_out;
  logic [63:0] drv_out;

  int total = 0, bad = 0;
  exp_t q[$];
  logic [N-1:0] m0 = '0, m1 = '0;
  logic [63:0] mh = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  dual_chain_driver i_dual_chain_driver (
    .clk(clk), .rst(rst), .shift_en(shift_en), .dir(dir),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .le(le), .blank_n(blank_n), .ser_out(ser_out), .drv_out(drv_out)
  );

  task automatic step(input logic r, input logic en, input logic dv,
                      input logic le_v, input logic bl_v, input string tag);
    exp_t e;
    logic [1:0] a, b;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    a = lfsr[1:0];
    b = lfsr[3:2];
    rst = r; shift_en = en; dir = dv; le = le_v; blank_n = bl_v;
    a_in = a; b_in = b;
    if (r) begin
      m0 = '0; m1 = '0; mh = '0;
    end else begin
      if (en && dv) begin
        m0 = {m0[N-2:0], a[0]}; m1 = {m1[N-2:0], a[1]};
      end else if (en) begin
        m0 = {b[0], m0[N-1:1]}; m1 = {b[1], m1[N-1:1]};
      end
      if (le_v) mh = {m1, m0};
    end
    e.par = bl_v ? (le_v ? {m1, m0} : mh) : 64'd0;
    e.ser = m1[N-1];
    // pins: {a_out, a_oe, b_out, b_oe}
    e.pins = dv ? {2'b00, 2'b00, m1[N-1], m0[N-1], 2'b11}
                : {m1[0], m0[0], 2'b11, 2'b00, 2'b00};
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (drv_out !== e.par) begin
          bad++;
          $display("FAIL %s drv_out actual=%h expected=%h", e.tag, drv_out, e.par);
        end
        total++;
        if (ser_out !== e.ser) begin
          bad++;
          $display("FAIL %s ser_out actual=%b expected=%b", e.tag, ser_out, e.ser);
        end
        total++;
        if ({a_out, a_oe, b_out, b_oe} !== e.pins) begin
          bad++;
          $display("FAIL %s pins actual=%b expected=%b", e.tag,
                   {a_out, a_oe, b_out, b_oe}, e.pins);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    repeat (2) step(1, 1, 1, 1, 1, "R1 reset");
    step(0, 0, 1, 1, 1, "R1 after reset");
    for (int i = 0; i < 40; i++) step(0, 1, 1, 1, 1, "R2/R5/R6/R9 forward");
    for (int i = 0; i < 4; i++)  step(0, 0, 1, 1, 1, "R4 shift off");
    for (int i = 0; i < 10; i++) step(0, 1, 1, 0, 1, "R7/R10 latch closed");
    for (int i = 0; i < 6; i++)  step(0, 1, 1, 0, 0, "R8/R10 blank closed");
    step(0, 0, 1, 0, 1, "R8 release shows held");
    for (int i = 0; i < 4; i++)  step(0, 1, 1, 1, 0, "R8 blank open");
    step(0, 0, 1, 1, 1, "R8 release open");
    for (int i = 0; i < 40; i++) step(0, 1, 0, 1, 1, "R3/R5/R6/R9 reverse");
    for (int i = 0; i < 8; i++)  step(0, 1, 0, 0, 0, "R7/R10 reverse closed");
    step(0, 0, 0, 1, 1, "R6 reopen");
    step(1, 1, 0, 1, 1, "R1 reset again");
    step(0, 0, 0, 1, 1, "R1 cleared");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule